// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block turns the individual interrupt conditions of a 16550-style serial port into a single interrupt request and an interrupt identification byte. It holds one pending flag for each of five sources: line status, character timeout, received data, transmit holding register empty and modem status. Each flag is raised and dropped by single-cycle pulses from the neighbouring receive, transmit and modem logic. A four-bit enable register decides which flags may take part. A fixed priority chain then picks the most urgent enabled flag and reports its code.

The block also arms and clears the transmit-empty source itself. Software can write the enable register with the transmit-empty enable set while the holding register is already empty. When it does, that source becomes pending without waiting for a new empty event. When software reads the identification byte while it shows the transmit-empty code, that source is cleared. The interrupt request reaches the pin only while the modem-control auxiliary output that gates interrupts is set. The two top bits of the identification byte report whether the FIFOs are on.

No data stream passes through this block, so it has no valid/ready interface and no back-pressure. All pins are plain control and status signals: single-cycle strobes in, levels out.

Top module: `uart_irq_encoder`

## Requirements
- R1: After reset the enable register reads 0, no source is pending, `iir` reads 0x01 and `irq` is low.
- R2: An enable write stores only `ier_wdata[3:0]` into `ier_q`, and bits 7:4 of the write have no effect. Bit 0 gates both received data and timeout, bit 1 gates transmit-empty, bit 2 gates line status and bit 3 gates modem status.
- R3: Priority, from highest to lowest, with the code shown in `iir[3:0]`: line status 0x6, character timeout 0xC, received data 0x4, transmit-empty 0x2, modem status 0x0.
- R4: A pending source whose enable bit is clear neither appears in `iir` nor raises `irq`.
- R5: When no enabled source is pending, `iir[3:0]` reads 0x1. When one is pending, `iir[0]` reads 0.
- R6: `iir[7:6]` read 2'b11 while `fifo_en` is high and 2'b00 otherwise. `iir[5:4]` always read 0.
- R7: `irq` is high exactly when an enabled source is pending and `out2` is high. Dropping `out2` lowers `irq` without changing `iir`.
- R8: Source pulses use the one-hot positions line status = bit 0, received data = bit 1, transmit-empty = bit 2, modem status = bit 3, timeout = bit 4. A `src_set` bit makes that source pending from the next cycle. A `src_clr` bit clears it from the next cycle. When both arrive in the same cycle, set wins.
- R9: An enable write with `ier_wdata[1]` = 1 while `thr_empty` is high makes transmit-empty pending from the next cycle. The same write with `thr_empty` low does not.
- R10: An `iir_rd` strobe while `iir[3:0]` = 0x2 clears transmit-empty from the next cycle. A read while a different code is shown leaves transmit-empty pending.
- R11: If an arming enable write (R9) and a clearing `iir_rd` (R10) happen in the same cycle, transmit-empty stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 8 | Enable-register write data |
| ier_q | output | 4 | Stored enable bits |
| src_set | input | 5 | One-hot set pulses per source |
| src_clr | input | 5 | One-hot clear pulses per source |
| thr_empty | input | 1 | Transmit holding register empty status |
| iir_rd | input | 1 | Identification-byte read strobe |
| out2 | input | 1 | Modem-control interrupt gate |
| fifo_en | input | 1 | FIFOs enabled |
| iir | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request |

## Verification
Two actions can land on the transmit-empty flag in the same cycle. A read of the identification byte while it shows code 0x2 tries to clear the flag. An enable write with bit 1 set while the holding register is empty tries to arm it. The bench first leaves transmit-empty as the only enabled pending source, holds `thr_empty` high, and then pulses `iir_rd` and `ier_wr` on the same edge. It passes only if code 0x2 and `irq` are still present one cycle later. A companion case puts a `src_set` and a `src_clr` pulse on one source in the same cycle and requires the source to end up pending.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int IER_W   = 4;
  localparam int BUS_W   = 8;

  // one-hot source positions
  localparam int SRC_LSR = 0;
  localparam int SRC_RX  = 1;
  localparam int SRC_THR = 2;
  localparam int SRC_MSR = 3;
  localparam int SRC_TMO = 4;

  // enable bit positions
  localparam int EN_RX  = 0;
  localparam int EN_THR = 1;
  localparam int EN_LSR = 2;
  localparam int EN_MSR = 3;

  localparam logic [3:0] CODE_LSR  = 4'h6;
  localparam logic [3:0] CODE_TMO  = 4'hC;
  localparam logic [3:0] CODE_RX   = 4'h4;
  localparam logic [3:0] CODE_THR  = 4'h2;
  localparam logic [3:0] CODE_MSR  = 4'h0;
  localparam logic [3:0] CODE_NONE = 4'h1;
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);
  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_o);
endmodule

// File: rtl/uart_irq_ier.sv
module uart_irq_ier
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             thr_empty_i,
  output logic [IER_W-1:0] ier_o,
  output logic             arm_thr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ier_o <= '0;
    else if (wr_i) ier_o <= wdata_i[IER_W-1:0];
  end

  assign arm_thr_o = wr_i && wdata_i[EN_THR] && thr_empty_i;

  // R2
  ier_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (ier_o == $past(wdata_i[IER_W-1:0])));
  // R2
  ier_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ier_o));
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [IER_W-1:0]   ier_i,
  input  logic               fifo_en_i,
  input  logic               out2_i,
  output logic [BUS_W-1:0]   iir_o,
  output logic               irq_o,
  output logic               shows_thr_o
);
  logic [3:0] code;
  logic       any;

  always_comb begin
    any  = 1'b1;
    code = CODE_NONE;
    if (ier_i[EN_LSR] && pend_i[SRC_LSR])      code = CODE_LSR;
    else if (ier_i[EN_RX] && pend_i[SRC_TMO])  code = CODE_TMO;
    else if (ier_i[EN_RX] && pend_i[SRC_RX])   code = CODE_RX;
    else if (ier_i[EN_THR] && pend_i[SRC_THR]) code = CODE_THR;
    else if (ier_i[EN_MSR] && pend_i[SRC_MSR]) code = CODE_MSR;
    else                                       any  = 1'b0;
  end

  assign iir_o       = {{2{fifo_en_i}}, 2'b00, code};
  assign irq_o       = any && out2_i;
  assign shows_thr_o = any && (code == CODE_THR);
endmodule

// File: rtl/uart_irq_encoder.sv
module uart_irq_encoder
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ier_wr,
  input  logic [BUS_W-1:0]   ier_wdata,
  output logic [IER_W-1:0]   ier_q,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic [NUM_SRC-1:0] src_clr,
  input  logic               thr_empty,
  input  logic               iir_rd,
  input  logic               out2,
  input  logic               fifo_en,
  output logic [BUS_W-1:0]   iir,
  output logic               irq
);
  logic               arm_thr;
  logic               shows_thr;
  logic [NUM_SRC-1:0] set_v;
  logic [NUM_SRC-1:0] clr_v;
  logic [NUM_SRC-1:0] pend;

  uart_irq_ier u_ier (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (ier_wr),
    .wdata_i    (ier_wdata),
    .thr_empty_i(thr_empty),
    .ier_o      (ier_q),
    .arm_thr_o  (arm_thr)
  );

  always_comb begin
    set_v = src_set;
    clr_v = src_clr;
    set_v[SRC_THR] = src_set[SRC_THR] | arm_thr;
    clr_v[SRC_THR] = src_clr[SRC_THR] | (iir_rd & shows_thr);
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    uart_irq_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .pend_o(pend[g])
    );
  end

  uart_irq_prio u_prio (
    .pend_i     (pend),
    .ier_i      (ier_q),
    .fifo_en_i  (fifo_en),
    .out2_i     (out2),
    .iir_o      (iir),
    .irq_o      (irq),
    .shows_thr_o(shows_thr)
  );

  // R9
  thr_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && ier_wdata[EN_THR] && thr_empty) |=> pend[SRC_THR]);
  // R10
  thr_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir[3:0] == CODE_THR && !src_set[SRC_THR] && !arm_thr)
      |=> !pend[SRC_THR]);
  // R5
  irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !iir[0]);
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out2 |-> !irq);
endmodule

// File: tb/uart_irq_encoder_tb.sv
module uart_irq_encoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ier_wr = 1'b0;
  logic [7:0] ier_wdata = '0;
  logic [3:0] ier_q;
  logic [4:0] src_set = '0;
  logic [4:0] src_clr = '0;
  logic       thr_empty = 1'b0;
  logic       iir_rd = 1'b0;
  logic       out2 = 1'b0;
  logic       fifo_en = 1'b0;
  logic [7:0] iir;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  uart_irq_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .ier_q(ier_q), .src_set(src_set), .src_clr(src_clr),
    .thr_empty(thr_empty), .iir_rd(iir_rd), .out2(out2),
    .fifo_en(fifo_en), .iir(iir), .irq(irq)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wr = 1'b1; ier_wdata = v;
    step();
    ier_wr = 1'b0; ier_wdata = '0;
  endtask

  task automatic pulse(input logic [4:0] s, input logic [4:0] c);
    src_set = s; src_clr = c;
    step();
    src_set = '0; src_clr = '0;
  endtask

  task automatic clean();
    pulse(5'b00000, 5'b11111);
    wr_ier(8'h00);
    out2 = 1'b0; fifo_en = 1'b0; thr_empty = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 iir", iir, 8'h01);
    chk("R1 irq", irq, 0);
    chk("R1 ier", ier_q, 0);
  endtask

  task automatic t_ier_mask();
    wr_ier(8'hFA);
    chk("R2 low bits", ier_q, 4'hA);
    wr_ier(8'h35);
    chk("R2 low bits", ier_q, 4'h5);
    clean();
  endtask

  task automatic t_priority();
    out2 = 1'b1;
    wr_ier(8'h0F);
    pulse(5'b11111, 5'b00000);
    chk("R3 lsr", iir, 8'h06);
    chk("R7 irq", irq, 1);
    pulse(5'b00000, 5'b00001);
    chk("R3 timeout", iir, 8'h0C);
    pulse(5'b00000, 5'b10000);
    chk("R3 rx", iir, 8'h04);
    pulse(5'b00000, 5'b00010);
    chk("R3 thr", iir, 8'h02);
    pulse(5'b00000, 5'b00100);
    chk("R3 modem", iir, 8'h00);
    pulse(5'b00000, 5'b01000);
    chk("R5 none", iir, 8'h01);
    chk("R5 irq", irq, 0);
    clean();
  endtask

  task automatic t_gating();
    out2 = 1'b1;
    pulse(5'b11111, 5'b00000);
    chk("R4 masked iir", iir, 8'h01);
    chk("R4 masked irq", irq, 0);
    wr_ier(8'h08);
    chk("R4 modem only", iir, 8'h00);
    wr_ier(8'h02);
    chk("R4 thr only", iir, 8'h02);
    wr_ier(8'h01);
    chk("R4 bit0 timeout", iir, 8'h0C);
    pulse(5'b00000, 5'b10000);
    chk("R4 bit0 rx", iir, 8'h04);
    wr_ier(8'h04);
    chk("R4 lsr only", iir, 8'h06);
    clean();
  endtask

  task automatic t_fifo();
    fifo_en = 1'b1;
    step();
    chk("R6 fifo none", iir, 8'hC1);
    wr_ier(8'h04);
    pulse(5'b00001, 5'b00000);
    chk("R6 fifo lsr", iir, 8'hC6);
    fifo_en = 1'b0;
    step();
    chk("R6 no fifo", iir, 8'h06);
    clean();
  endtask

  task automatic t_out2();
    wr_ier(8'h08);
    pulse(5'b01000, 5'b00000);
    out2 = 1'b1;
    step();
    chk("R7 irq on", irq, 1);
    out2 = 1'b0;
    step();
    chk("R7 irq off", irq, 0);
    chk("R7 iir kept", iir, 8'h00);
    clean();
  endtask

  task automatic t_set_clr();
    wr_ier(8'h01);
    pulse(5'b00010, 5'b00010);
    chk("R8 set wins", iir, 8'h04);
    pulse(5'b00000, 5'b00010);
    chk("R8 clear", iir, 8'h01);
    clean();
  endtask

  task automatic t_arm();
    out2 = 1'b1;
    thr_empty = 1'b0;
    wr_ier(8'h02);
    chk("R9 no arm", iir, 8'h01);
    thr_empty = 1'b1;
    wr_ier(8'h02);
    chk("R9 armed", iir, 8'h02);
    chk("R9 irq", irq, 1);
    clean();
  endtask

  task automatic t_iir_read();
    wr_ier(8'h02);
    pulse(5'b00100, 5'b00000);
    iir_rd = 1'b1;
    step();
    iir_rd = 1'b0;
    chk("R10 read clears", iir, 8'h01);
    wr_ier(8'h03);
    pulse(5'b00110, 5'b00000);
    iir_rd = 1'b1;
    step();
    iir_rd = 1'b0;
    chk("R10 other code", iir, 8'h04);
    pulse(5'b00000, 5'b00010);
    chk("R10 thr kept", iir, 8'h02);
    clean();
  endtask

  task automatic t_race();
    out2 = 1'b1;
    wr_ier(8'h02);
    pulse(5'b00100, 5'b00000);
    thr_empty = 1'b1;
    iir_rd = 1'b1; ier_wr = 1'b1; ier_wdata = 8'h02;
    step();
    iir_rd = 1'b0; ier_wr = 1'b0; ier_wdata = '0;
    chk("R11 arm beats read", iir, 8'h02);
    chk("R11 irq", irq, 1);
    clean();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_ier_mask();
    t_priority();
    t_gating();
    t_fifo();
    t_out2();
    t_set_clr();
    t_arm();
    t_iir_read();
    t_race();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule